// File: doc/BRIEF.md
# Two-Phase Virtual Channel Class Selector for a 2D Mesh Router

This block sits on one input port of a 2D mesh router and decides, for the packet at the head of that port, which output port and which virtual channel it takes on the next hop. Every output port has two disjoint groups of virtual channels. Adaptive channels may carry a packet in any direction that brings it closer to its destination. Escape channels are reserved for deterministic routing that resolves X fully before Y, and that routing has an acyclic channel dependence graph. A packet starts in the adaptive phase. In the cycle where no adaptive channel on any productive port is free, it falls back to the escape group. A phase bit carried in the packet header records this fallback, and it never returns to adaptive routing.

The router supplies the current and destination coordinates, the header's phase bit, and per-port, per-channel free flags for both groups. The selector registers its decision and presents it one clock cycle after the request. If the required escape channel is also busy, it signals a stall and leaves its previous choice on the outputs. Arbitration between input ports and packet buffering belong to other blocks.

Top module: `esc_vc_selector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sel_valid`, `stall`, `out_port`, `out_vc` and `phase_out` are all zero.
- R2: A request whose destination equals the current node yields, one cycle later, `sel_valid`=1, `out_port`=4 (local) and `out_vc`=0, with `phase_out` equal to `phase_in`. The free flags play no part in this case.
- R3: Port codes are 0=+X, 1=-X, 2=+Y, 3=-Y, 4=local. With `phase_in`=0, at least one productive port has a free adaptive channel. Adaptive channel v of port p is flag bit p*ADAPT_VCS+v. The selector then picks the lowest-numbered such port and, within it, the lowest-numbered free adaptive channel, reported as `out_vc`=v. It reports `phase_out`=0.
- R4: An adaptive choice is always on a productive port: +X only when dst_x>cur_x, -X only when dst_x<cur_x, +Y only when dst_y>cur_y, -Y only when dst_y<cur_y.
- R5: With `phase_in`=0 and no free adaptive channel on any productive port, the packet uses the dimension-order port in the same cycle. Escape channel e of port p is flag bit p*ESC_VCS+e. The selector takes the lowest free escape channel there and reports `out_vc`=ADAPT_VCS+e and `phase_out`=1.
- R6: With `phase_in`=1, the adaptive free flags are ignored. The packet always takes the dimension-order port and an escape channel, and `phase_out` stays 1.
- R7: The dimension-order port is +X or -X whenever the X coordinates differ. It is +Y or -Y only when they are equal.
- R8: When escape routing is required and no escape channel on the dimension-order port is free, the selector reports `stall`=1 and `sel_valid`=0 one cycle later. `out_port`, `out_vc` and `phase_out` keep their previous values.
- R9: Without `req_valid`, `sel_valid` and `stall` are both 0 in the following cycle and the other outputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A head packet requests a route this cycle |
| cur_x | input | COORD_W | X coordinate of this router |
| cur_y | input | COORD_W | Y coordinate of this router |
| dst_x | input | COORD_W | Destination X from the header |
| dst_y | input | COORD_W | Destination Y from the header |
| phase_in | input | 1 | Header phase bit, 1 = already in escape routing |
| adapt_free | input | 4*ADAPT_VCS | Adaptive channel free flags, bit p*ADAPT_VCS+v |
| esc_free | input | 4*ESC_VCS | Escape channel free flags, bit p*ESC_VCS+e |
| sel_valid | output | 1 | A selection was made for last cycle's request |
| stall | output | 1 | Last cycle's request found no usable channel |
| out_port | output | 3 | Chosen output port code |
| out_vc | output | clog2(ADAPT_VCS+ESC_VCS) | Chosen channel index, escape channels above adaptive |
| phase_out | output | 1 | Updated phase bit for the header |

## Verification
The bench builds the selector with COORD_W=3, ADAPT_VCS=2 and ESC_VCS=2, which gives an 8x8 mesh with four channels per port. With two channels in each group, both the lowest-free-channel choice inside a port and the escape index offset (values 2 and 3) can be observed. The 8x8 range covers all four sign combinations of the coordinate differences, including one axis aligned and both axes aligned. Sparse random free masks make full adaptive blocking, and escape blocking on top of it, frequent enough to reach the fallback and stall paths often.

// File: rtl/esc_vc_pkg.sv
package esc_vc_pkg;
  localparam int MESH_PORTS = 4;
  localparam logic [2:0] PORT_XP = 3'd0;
  localparam logic [2:0] PORT_XN = 3'd1;
  localparam logic [2:0] PORT_YP = 3'd2;
  localparam logic [2:0] PORT_YN = 3'd3;
  localparam logic [2:0] PORT_LOC = 3'd4;
endpackage

// File: rtl/esc_vc_route.sv
module esc_vc_route
  import esc_vc_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0]    cur_x,
  input  logic [COORD_W-1:0]    cur_y,
  input  logic [COORD_W-1:0]    dst_x,
  input  logic [COORD_W-1:0]    dst_y,
  output logic [MESH_PORTS-1:0] prod,
  output logic                  at_dest,
  output logic [2:0]            dor_port
);
  always_comb begin
    prod[0] = dst_x > cur_x;
    prod[1] = dst_x < cur_x;
    prod[2] = dst_y > cur_y;
    prod[3] = dst_y < cur_y;
    at_dest = ~|prod;
  end

  // X is resolved completely before Y (dimension order)
  always_comb begin
    if (prod[0])      dor_port = PORT_XP;
    else if (prod[1]) dor_port = PORT_XN;
    else if (prod[2]) dor_port = PORT_YP;
    else if (prod[3]) dor_port = PORT_YN;
    else              dor_port = PORT_LOC;
  end
endmodule

// File: rtl/esc_vc_pick.sv
module esc_vc_pick #(
  parameter int W     = 4,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/esc_vc_selector.sv
module esc_vc_selector
  import esc_vc_pkg::*;
#(
  parameter int COORD_W   = 3,
  parameter int ADAPT_VCS = 2,
  parameter int ESC_VCS   = 2,
  localparam int VC_W     = $clog2(ADAPT_VCS + ESC_VCS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic [COORD_W-1:0]              cur_x,
  input  logic [COORD_W-1:0]              cur_y,
  input  logic [COORD_W-1:0]              dst_x,
  input  logic [COORD_W-1:0]              dst_y,
  input  logic                            phase_in,
  input  logic [MESH_PORTS*ADAPT_VCS-1:0] adapt_free,
  input  logic [MESH_PORTS*ESC_VCS-1:0]   esc_free,
  output logic                            sel_valid,
  output logic                            stall,
  output logic [2:0]                      out_port,
  output logic [VC_W-1:0]                 out_vc,
  output logic                            phase_out
);
  localparam int AI_W = (ADAPT_VCS > 1) ? $clog2(ADAPT_VCS) : 1;
  localparam int EI_W = (ESC_VCS > 1) ? $clog2(ESC_VCS) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // direction analysis
  logic [MESH_PORTS-1:0] prod;
  logic                  at_dest;
  logic [2:0]            dor_port;
  esc_vc_route #(.COORD_W(COORD_W)) u_route (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .prod(prod), .at_dest(at_dest), .dor_port(dor_port)
  );

  // adaptive candidates per mesh port
  logic [MESH_PORTS-1:0] ad_any;
  logic [MESH_PORTS-1:0] ad_ok;
  logic [AI_W-1:0]       ad_idx [MESH_PORTS];
  for (genvar p = 0; p < MESH_PORTS; p++) begin : g_adapt
    esc_vc_pick #(.W(ADAPT_VCS), .IDX_W(AI_W)) u_pick (
      .vec(adapt_free[p*ADAPT_VCS +: ADAPT_VCS]),
      .hit(ad_any[p]),
      .idx(ad_idx[p])
    );
    assign ad_ok[p] = prod[p] & ad_any[p];
  end

  logic       adapt_hit;
  logic [1:0] adapt_sel;
  esc_vc_pick #(.W(MESH_PORTS), .IDX_W(2)) u_port_pick (
    .vec(ad_ok), .hit(adapt_hit), .idx(adapt_sel)
  );

  // escape candidates on the dimension-order port
  logic [ESC_VCS-1:0] esc_vec;
  always_comb begin
    esc_vec = '0;
    for (int p = 0; p < MESH_PORTS; p++) begin
      if (dor_port == 3'(p)) esc_vec = esc_free[p*ESC_VCS +: ESC_VCS];
    end
  end

  logic            esc_hit;
  logic [EI_W-1:0] esc_idx;
  esc_vc_pick #(.W(ESC_VCS), .IDX_W(EI_W)) u_esc_pick (
    .vec(esc_vec), .hit(esc_hit), .idx(esc_idx)
  );

  // next-state decision
  logic            valid_n, stall_n, load_n, phase_n;
  logic [2:0]      port_n;
  logic [VC_W-1:0] vc_n;
  always_comb begin
    valid_n = 1'b0;
    stall_n = 1'b0;
    load_n  = 1'b0;
    port_n  = out_port;
    vc_n    = out_vc;
    phase_n = phase_out;
    if (req_valid) begin
      if (at_dest) begin
        valid_n = 1'b1;
        load_n  = 1'b1;
        port_n  = PORT_LOC;
        vc_n    = '0;
        phase_n = phase_in;
      end else if (!phase_in && adapt_hit) begin
        valid_n = 1'b1;
        load_n  = 1'b1;
        port_n  = {1'b0, adapt_sel};
        vc_n    = VC_W'(ad_idx[adapt_sel]);
        phase_n = 1'b0;
      end else if (esc_hit) begin
        valid_n = 1'b1;
        load_n  = 1'b1;
        port_n  = dor_port;
        vc_n    = VC_W'(ADAPT_VCS) + VC_W'(esc_idx);
        phase_n = 1'b1;
      end else begin
        stall_n = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sel_valid <= 1'b0;
      stall     <= 1'b0;
    end else begin
      sel_valid <= valid_n;
      stall     <= stall_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_port  <= '0;
      out_vc    <= '0;
      phase_out <= 1'b0;
    end else if (load_n) begin
      out_port  <= port_n;
      out_vc    <= vc_n;
      phase_out <= phase_n;
    end
  end

  // assertions
  logic need_esc;
  assign need_esc = req_valid && !at_dest && (phase_in || !adapt_hit);

  a_r4_productive: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && !phase_in && adapt_hit) |-> prod[adapt_sel]);

  a_r5_fallback: assert property (@(posedge clk) disable iff (!rst_q)
    (need_esc && !phase_in && esc_hit) |=>
      (sel_valid && phase_out && out_vc >= VC_W'(ADAPT_VCS)));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && phase_in) |=> (stall || (sel_valid && phase_out)));

  a_r7_x_first: assert property (@(posedge clk) disable iff (!rst_q)
    (need_esc && esc_hit && (prod[0] || prod[1])) |=> (out_port <= PORT_XN));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (need_esc && !esc_hit) |=>
      (stall && !sel_valid && $stable(out_port) && $stable(out_vc) && $stable(phase_out)));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({sel_valid, stall}));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> (!sel_valid && !stall));
endmodule

// File: tb/esc_vc_selector_bench.sv
`timescale 1ns/1ps
module esc_vc_selector_bench;
  localparam int CW = 3;
  localparam int NA = 2;
  localparam int NE = 2;
  localparam int VW = $clog2(NA + NE);
  localparam int OW = 3 + VW + 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, phase_in;
  logic [CW-1:0] cur_x, cur_y, dst_x, dst_y;
  logic [4*NA-1:0] adapt_free;
  logic [4*NE-1:0] esc_free;
  logic sel_valid, stall, phase_out;
  logic [2:0] out_port;
  logic [VW-1:0] out_vc;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  // expected state kept by the bench
  logic e_valid, e_stall, e_phase;
  logic [2:0] e_port;
  logic [VW-1:0] e_vc;
  string e_tag;

  always #10 clk = ~clk;

  esc_vc_selector #(.COORD_W(CW), .ADAPT_VCS(NA), .ESC_VCS(NE)) u_esc_vc_selector (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .phase_in(phase_in), .adapt_free(adapt_free), .esc_free(esc_free),
    .sel_valid(sel_valid), .stall(stall), .out_port(out_port),
    .out_vc(out_vc), .phase_out(phase_out)
  );

  function automatic logic [OW-1:0] pack_out(logic v, logic s, logic [2:0] p,
                                             logic [VW-1:0] c, logic ph);
    return {v, s, p, c, ph};
  endfunction

  task automatic check(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // reference from the requirements
  task automatic model();
    logic [3:0] pr;
    logic [2:0] dor;
    bit found;
    e_valid = 1'b0;
    e_stall = 1'b0;
    if (!req_valid) begin
      e_tag = "R9";
      return;
    end
    pr = {dst_y < cur_y, dst_y > cur_y, dst_x < cur_x, dst_x > cur_x};
    if (pr == 4'b0) begin
      e_tag = "R2"; e_valid = 1'b1; e_port = 3'd4; e_vc = '0; e_phase = phase_in;
      return;
    end
    found = 1'b0;
    if (!phase_in) begin
      for (int p = 0; p < 4 && !found; p++) begin
        for (int v = 0; v < NA && !found; v++) begin
          if (pr[p] && adapt_free[p*NA+v]) begin
            found = 1'b1; e_port = 3'(p); e_vc = VW'(v);
          end
        end
      end
    end
    if (found) begin
      e_tag = "R3"; e_valid = 1'b1; e_phase = 1'b0;
      return;
    end
    // R7: X before Y
    if (pr[0]) dor = 3'd0; else if (pr[1]) dor = 3'd1;
    else if (pr[2]) dor = 3'd2; else dor = 3'd3;
    for (int e = 0; e < NE && !found; e++) begin
      if (esc_free[int'(dor)*NE+e]) begin
        found = 1'b1; e_port = dor; e_vc = VW'(NA + e);
      end
    end
    if (found) begin
      e_tag = phase_in ? "R6" : "R5"; e_valid = 1'b1; e_phase = 1'b1;
    end else begin
      e_tag = "R8"; e_stall = 1'b1;
    end
  endtask

  task automatic apply(logic v, int cx, int cy, int dx, int dy, logic ph,
                       logic [4*NA-1:0] af, logic [4*NE-1:0] ef, string note);
    req_valid = v; cur_x = CW'(cx); cur_y = CW'(cy); dst_x = CW'(dx); dst_y = CW'(dy);
    phase_in = ph; adapt_free = af; esc_free = ef;
    model();
    @(negedge clk);
    check({e_tag, note}, pack_out(sel_valid, stall, out_port, out_vc, phase_out),
          pack_out(e_valid, e_stall, e_port, e_vc, e_phase));
  endtask

  initial begin
    int lim;
    lim = 100000;
    repeat (lim) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b1; req_valid = 1'b0; phase_in = 1'b0;
    cur_x = '0; cur_y = '0; dst_x = '0; dst_y = '0; adapt_free = '0; esc_free = '0;
    e_valid = 1'b0; e_stall = 1'b0; e_phase = 1'b0; e_port = '0; e_vc = '0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R1 in reset", pack_out(sel_valid, stall, out_port, out_vc, phase_out), '0);
    req_valid = 1'b1; adapt_free = '1; esc_free = '1; dst_x = 3'd5;
    repeat (2) @(negedge clk);
    check("R1 reset holds", pack_out(sel_valid, stall, out_port, out_vc, phase_out), '0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", pack_out(sel_valid, stall, out_port, out_vc, phase_out), '0);
    repeat (2) @(negedge clk);

    // directed corner cases
    apply(1, 3, 3, 3, 3, 0, '0, '0, " dest local");
    apply(1, 2, 2, 2, 2, 1, '1, '1, " dest keeps phase");
    apply(1, 1, 1, 5, 6, 0, 8'hFF, 8'hFF, " lowest port +X");
    apply(1, 1, 1, 5, 6, 0, 8'b0010_0000, 8'hFF, " +Y vc1 only");
    apply(1, 6, 6, 2, 1, 0, 8'b1000_0100, 8'h00, " -X vc0");
    apply(1, 6, 6, 2, 1, 0, 8'b1111_0011, 8'hFF, " R4 blocked -X, only nonproductive free besides -Y");
    apply(1, 1, 1, 5, 6, 0, 8'b1100_1100, 8'b0000_0010, " R7 fallback to +X esc vc3");
    apply(1, 4, 6, 4, 1, 0, 8'b0011_1111, 8'b0100_0000, " fallback -Y esc vc2");
    apply(1, 1, 1, 5, 6, 1, 8'hFF, 8'b0000_0001, " escape ignores adaptive");
    apply(1, 7, 0, 0, 7, 1, 8'hFF, 8'b0000_1100, " R7 escape -X not +Y");
    apply(1, 1, 1, 5, 6, 0, 8'h00, 8'b1111_1100, " stall holds");
    apply(1, 1, 1, 5, 6, 1, 8'hFF, 8'h00, " stall in escape");
    apply(0, 1, 1, 5, 6, 0, 8'hFF, 8'hFF, " idle holds");
    apply(1, 0, 0, 0, 4, 0, 8'b0000_0000, 8'b0011_0000, " fallback +Y");

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic v, ph;
      v  = ($urandom % 10) != 0;
      ph = ($urandom % 4) == 0;
      apply(v, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
            ph, 8'($urandom & $urandom), 8'($urandom & $urandom), " random");
      // R4: any adaptive result must be on a productive port
      if (e_tag == "R3") begin
        logic okp;
        case (out_port)
          3'd0: okp = dst_x > cur_x;
          3'd1: okp = dst_x < cur_x;
          3'd2: okp = dst_y > cur_y;
          3'd3: okp = dst_y < cur_y;
          default: okp = 1'b0;
        endcase
        check("R4 productive", {{(OW-1){1'b0}}, okp}, {{(OW-1){1'b0}}, 1'b1});
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule